// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

This block resolves which of several interrupting interfaces gets serviced when all of them share one request wire. Each interface owns a cell. A pulse on a cell's local source marks it pending. Every pending cell pulls the shared active-low request line low. The wired-OR of these open-drain pulls is modelled as a logical AND of the per-cell active-low drives.

A small controller on the processor side watches the shared line. When the line is low, the controller raises an acknowledge level. That level enters cell 0 and ripples combinationally down the chain. The first pending cell that sees the acknowledge rise at its input takes it. That cell stops the acknowledge from going further and sets a captured status bit, which a polling routine reads to learn which interface to serve. Priority therefore follows chain position, and cell 0 ranks highest.

Software ends the service by a clear strobe. The acknowledge then falls. On that fall the captured cell drops both its pending request and its status. The controller then waits one idle cycle before it looks at the line again. The acknowledge leaving the last cell is brought out, so that the chain can be extended.

Top module: `irq_chain_top`

## Requirements
- R1: While reset is held, the shared request line is high, acknowledge is low, no captured status bit is set and the chain-end acknowledge is low.
- R2: A high level on bit i of the source input for one cycle makes cell i pending from the next cycle. The pending state holds until that cell is serviced. The shared request line is low exactly while at least one cell is pending.
- R3: With the controller idle, a low shared request line sampled at a clock edge raises acknowledge in the cycle after that edge.
- R4: In the cycle after acknowledge rises, the captured status bit is set for the lowest-numbered cell that was pending during the rise cycle, and for no other cell.
- R5: Acknowledge does not pass a cell that is capturing or has captured it, so cells further along the chain and the chain-end output see it low.
- R6: A cell with no pending request passes acknowledge through unchanged in the same cycle.
- R7: A cell that becomes pending while acknowledge is already high at its input does not capture it. It keeps passing acknowledge, and the existing captured status stays where it is.
- R8: Once raised, acknowledge stays high until a clear strobe is sampled. It then goes low for at least two cycles: the fall cycle and one gap cycle. A clear strobe while acknowledge is low has no effect.
- R9: The edge that samples acknowledge low at the captured cell clears that cell's status bit and pending state. Other pending cells are kept and are serviced by later acknowledges.
- R10: At most one captured status bit is set at any time.
- R11: A source pulse that arrives in the same cycle that the cell's pending state is cleared leaves the cell pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_CELLS | Local interrupt source pulse per cell, bit 0 is nearest the controller |
| swClear | input | 1 | Software clear strobe that ends the current acknowledge |
| reqLineN | output | 1 | Shared active-low request line (AND of all cell drives) |
| ackOut | output | 1 | Acknowledge level driven into cell 0 |
| capturedStatus | output | NUM_CELLS | Per-cell captured status, bit i for cell i |
| chainEndAck | output | 1 | Acknowledge leaving the last cell |

## Verification
The bench builds the chain with five cells. With five cells it can place requests at the head, the tail and in the middle. It can also make three or more cells compete at once, and have a head cell arrive late while a tail cell holds the acknowledge. A clear strobe is timed so that the gap cycle coincides with a fresh source pulse on the captured cell. A long pseudo-random phase then mixes source pulses and clear strobes across all five positions. This exercises the priority order and the single-captor property under interleavings that the directed cases do not reach.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_ACK  = 2'd1,
    CTL_GAP  = 2'd2
  } ctlStateT;

  typedef struct packed {
    logic ackLevel;
  } ctlStrobeT;

endpackage

// File: rtl/irq_cell.sv
module irq_cell (
  input  logic clk,
  input  logic rstN,
  input  logic srcPulse,
  input  logic ackIn,
  output logic ackOut,
  output logic reqDrvN,
  output logic captured
);

  logic pendQ;
  logic capQ;
  logic ackInQ;
  logic ackRise;
  logic grab;
  logic dropCap;

  // capture is decided only on a rising acknowledge at this cell's input
  assign ackRise = ackIn & ~ackInQ;
  assign grab    = pendQ & ackRise;
  assign dropCap = capQ & ~ackIn;

  assign ackOut   = ackIn & ~capQ & ~grab;
  assign reqDrvN  = ~pendQ;
  assign captured = capQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      capQ   <= 1'b0;
      ackInQ <= 1'b0;
    end else begin
      ackInQ <= ackIn;
      capQ   <= grab | (capQ & ~dropCap);
      pendQ  <= srcPulse | (pendQ & ~dropCap);
    end
  end

endmodule

// File: rtl/irq_chain_dp.sv
module irq_chain_dp
  import irq_chain_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            strobe,
  input  logic [NUM_CELLS-1:0] srcReq,
  output logic                 reqLineN,
  output logic [NUM_CELLS-1:0] capturedStatus,
  output logic                 chainEndAck
);

  localparam int LINKS = NUM_CELLS + 1;

  logic [LINKS-1:0]     ackLink;
  logic [NUM_CELLS-1:0] drvN;

  assign ackLink[0] = strobe.ackLevel;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    irq_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .srcPulse (srcReq[i]),
      .ackIn    (ackLink[i]),
      .ackOut   (ackLink[i+1]),
      .reqDrvN  (drvN[i]),
      .captured (capturedStatus[i])
    );
  end

  // open-drain wired-OR of active-low drives
  assign reqLineN    = &drvN;
  assign chainEndAck = ackLink[LINKS-1];

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqLineN,
  input  logic      swClear,
  output ctlStrobeT strobe
);

  ctlStateT stateQ;
  ctlStateT stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CTL_IDLE: if (!reqLineN) stateD = CTL_ACK;
      CTL_ACK:  if (swClear)   stateD = CTL_GAP;
      CTL_GAP:                 stateD = CTL_IDLE;
      default:                 stateD = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= CTL_IDLE;
    else       stateQ <= stateD;
  end

  assign strobe.ackLevel = (stateQ == CTL_ACK);

endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
  import irq_chain_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CELLS-1:0] srcReq,
  input  logic                 swClear,
  output logic                 reqLineN,
  output logic                 ackOut,
  output logic [NUM_CELLS-1:0] capturedStatus,
  output logic                 chainEndAck
);

  ctlStrobeT strobe;

  irq_ack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqLineN (reqLineN),
    .swClear  (swClear),
    .strobe   (strobe)
  );

  irq_chain_dp #(.NUM_CELLS(NUM_CELLS)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .srcReq         (srcReq),
    .reqLineN       (reqLineN),
    .capturedStatus (capturedStatus),
    .chainEndAck    (chainEndAck)
  );

  assign ackOut = strobe.ackLevel;

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int NUM_CELLS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CELLS-1:0] srcReq,
  input logic                 swClear,
  input logic                 reqLineN,
  input logic                 ackOut,
  input logic [NUM_CELLS-1:0] capturedStatus,
  input logic                 chainEndAck
);

  // R10
  one_captor_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(capturedStatus));

  // R2
  src_pulls_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> !reqLineN);

  // R4
  rise_captures_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |=> (capturedStatus != '0));

  // R8
  ack_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && !swClear) |=> ackOut);

  // R8
  gap_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |=> !ackOut);

  // R9
  fall_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |=> (capturedStatus == '0));

  // R5
  end_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capturedStatus != '0) |-> !chainEndAck);

endmodule

bind irq_chain_top irq_chain_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .srcReq         (srcReq),
  .swClear        (swClear),
  .reqLineN       (reqLineN),
  .ackOut         (ackOut),
  .capturedStatus (capturedStatus),
  .chainEndAck    (chainEndAck)
);

// File: tb/irq_chain_top_bench.sv
module irq_chain_top_bench;

  localparam int N = 5;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcReq = '0;
  logic         swClear = 1'b0;
  logic         reqLineN;
  logic         ackOut;
  logic [N-1:0] capturedStatus;
  logic         chainEndAck;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_chain_top #(.NUM_CELLS(N)) u_irq_chain_top (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .swClear(swClear),
    .reqLineN(reqLineN), .ackOut(ackOut),
    .capturedStatus(capturedStatus), .chainEndAck(chainEndAck)
  );

  // behavioural reference
  bit [N-1:0] mPend;
  int         mCap = -1;
  int         mState = 0;   // 0 idle, 1 acknowledging, 2 gap
  bit         mAckPrev;

  function automatic bit expAck();
    return mState == 1;
  endfunction

  function automatic bit [N-1:0] expCap();
    bit [N-1:0] v = '0;
    if (mCap >= 0) v[mCap] = 1'b1;
    return v;
  endfunction

  function automatic bit expEnd();
    if (!expAck()) return 1'b0;
    if (mCap >= 0) return 1'b0;
    if (!mAckPrev && mPend != '0) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPend = '0; mCap = -1; mState = 0; mAckPrev = 1'b0;
    end else begin
      bit         ackNow;
      int         nCap;
      bit [N-1:0] nPend;
      ackNow = expAck();
      nCap = mCap;
      nPend = mPend;
      if (ackNow && !mAckPrev && mPend != '0) begin
        for (int i = N - 1; i >= 0; i--) if (mPend[i]) nCap = i;
      end
      if (mCap >= 0 && !ackNow) begin
        nPend[mCap] = 1'b0;
        nCap = -1;
      end
      nPend |= srcReq;
      case (mState)
        0: if (mPend != '0) mState = 1;
        1: if (swClear) mState = 2;
        default: mState = 0;
      endcase
      mPend = nPend;
      mCap = nCap;
      mAckPrev = ackNow;
    end
  end

  task automatic check1(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check1("R2 R9 R11 reqLineN", {{(N-1){1'b0}}, reqLineN}, {{(N-1){1'b0}}, ~|mPend});
      check1("R3 R8 ackOut", {{(N-1){1'b0}}, ackOut}, {{(N-1){1'b0}}, expAck()});
      check1("R4 R7 R9 R10 capturedStatus", capturedStatus, expCap());
      check1("R5 R6 chainEndAck", {{(N-1){1'b0}}, chainEndAck}, {{(N-1){1'b0}}, expEnd()});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [N-1:0] mask);
    @(negedge clk); srcReq = mask;
    @(negedge clk); srcReq = '0;
  endtask

  task automatic clr();
    @(negedge clk); swClear = 1'b1;
    @(negedge clk); swClear = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1 reset state
    check1("R1 reqLineN", {{(N-1){1'b0}}, reqLineN}, {{(N-1){1'b0}}, 1'b1});
    check1("R1 ackOut", {{(N-1){1'b0}}, ackOut}, '0);
    check1("R1 capturedStatus", capturedStatus, '0);
    check1("R1 chainEndAck", {{(N-1){1'b0}}, chainEndAck}, '0);
    rstN = 1'b1;
    idle(2);
    // single middle request (R2 R3 R4 R6)
    pulse(5'b00100); idle(5); clr(); idle(5);
    // two competing, lower index first (R4 R9)
    pulse(5'b01010); idle(5); clr(); idle(5); clr(); idle(4);
    // late head request while tail holds capture (R7 R5)
    pulse(5'b10000); idle(4); pulse(5'b00001); idle(4); clr(); idle(5); clr(); idle(4);
    // clear while idle is ignored (R8)
    clr(); idle(4);
    // source pulse during the clearing cycle (R11)
    pulse(5'b00010); idle(4); clr(); srcReq = 5'b00010; @(negedge clk); srcReq = '0;
    idle(5); clr(); idle(4);
    // all cells at once, drained in order (R10)
    pulse('1);
    for (int k = 0; k < N; k++) begin idle(3); clr(); end
    idle(5);
    // mixed pseudo-random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      srcReq = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      swClear = ($urandom_range(0, 3) == 0);
    end
    @(negedge clk); srcReq = '0; swClear = 1'b0;
    idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule